// File: doc/BRIEF.md
# Abort Time Stamp Capture Unit

This block keeps a microsecond counter that runs freely from the system clock and can be aligned to the host's time base. A prescaler turns the clock into a one-microsecond tick. The counter is zeroed whenever the decoded event stream carries the code held in the host-programmed alignment register. When an abort pulse arrives, the current count is copied into a 32-bit stamp register.

Together with the stamp, the block keeps a small set of cause flags: an abort marker, a dump-event marker, and live copies of the permit-failure and fiducial-failure indications. The abort marker freezes the stamp and every cause flag, so the host sees the state from the moment of the abort. A host read of the most significant stamp byte releases the freeze and clears the abort and dump markers. An interrupt request follows the latched markers and is gated by an enable bit.

Top module: `abort_stamp_unit`

## Requirements
- R1: The running count increases by exactly one every TICKS_PER_US clock cycles, counting from the edge that last cleared it.
- R2: An event whose code equals the alignment register (address 0) clears both the running count and the prescaler on the edge where it is sampled. Events with any other code leave the count unchanged.
- R3: On an abort pulse sampled while the abort marker (status bit 1) is clear, the count from before that edge is copied into the stamp register and the abort marker is set.
- R4: While the abort marker is set, further abort pulses leave the stamp unchanged, and every cause flag holds its value.
- R5: An event whose code equals the dump register (address 1) sets status bit 0 when the abort marker is clear. While the abort marker is set, the dump event is ignored.
- R6: While not frozen, status bit 2 follows the permit-failure input and status bit 3 follows the fiducial-failure input, each one cycle later.
- R7: The stamp is read least significant byte first at addresses 3, 4, 5 and 6, with read data valid one cycle after the read strobe. A read of address 6 clears status bits 0 and 1. Reads of addresses 2 to 5 clear nothing.
- R8: The irq output is high exactly when the enable (status bit 7, written at address 2) is set and status bit 0 or bit 1 is set.
- R9: Synchronous reset clears the count, the stamp, all cause flags, the enable bit and both code registers.
- R10: Addresses 0 and 1 are 8-bit read/write code registers. At address 2, only bit 7 is writable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_valid | input | 1 | Decoded event code present this cycle |
| evt_code | input | 8 | Decoded event code |
| abort_pulse | input | 1 | Abort occurred this cycle |
| permit_fail_in | input | 1 | Live permit-failure indication |
| fid_fail_in | input | 1 | Live fiducial-failure indication |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | 3 | Host write address |
| wr_data | input | 8 | Host write data |
| rd_en | input | 1 | Host read strobe |
| rd_addr | input | 3 | Host read address |
| rd_data | output | 8 | Read data, valid one cycle after rd_en |
| irq | output | 1 | Interrupt request |

## Verification
A wrong prescaler or a missed clear shows up in the captured stamp as an error of a whole count, so the bench sweeps the gap between the alignment event and the abort over many cycles and checks each value against the arithmetic quotient. A freeze that leaks shows up on the first status or stamp read after a second abort or a changed input. A wrong clear condition shows up on the irq pin in the cycle after the final byte read, or as a marker that is already gone after a partial read.

// File: rtl/abort_stamp_pkg.sv
package abort_stamp_pkg;
    localparam int TS_W   = 32;
    localparam int CODE_W = 8;
    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        A_ALIGN  = 3'd0,
        A_DUMP   = 3'd1,
        A_STATUS = 3'd2,
        A_TS0    = 3'd3,
        A_TS1    = 3'd4,
        A_TS2    = 3'd5,
        A_TS3    = 3'd6
    } reg_addr_e;

    typedef struct packed {
        logic fid_fail;
        logic permit_fail;
        logic rt_abort;
        logic dump;
    } cause_t;

    function automatic logic [CODE_W-1:0] stamp_byte(logic [TS_W-1:0] ts, logic [1:0] idx);
        return ts[idx*8 +: 8];
    endfunction

    function automatic logic [CODE_W-1:0] status_byte(cause_t c, logic en);
        return {en, 3'b000, c};
    endfunction
endpackage

// File: rtl/us_timebase.sv
module us_timebase #(
    parameter int TICKS_PER_US = 250,
    parameter int CNT_W        = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    output logic [CNT_W-1:0] cnt
);
    localparam int PRE_W = (TICKS_PER_US > 1) ? $clog2(TICKS_PER_US) : 1;
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICKS_PER_US - 1);

    logic [PRE_W-1:0] pre;
    logic             tick;

    assign tick = (pre == PRE_LAST);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            pre <= '0;
            cnt <= '0;
        end else if (tick) begin
            pre <= '0;
            cnt <= cnt + 1'b1;
        end else begin
            pre <= pre + 1'b1;
        end
    end

    // R2
    clr_zero_chk: assert property (@(posedge clk) disable iff (rst)
        clr |=> (cnt == '0) && (pre == '0));
    // R1
    step_chk: assert property (@(posedge clk) disable iff (rst)
        (!clr && tick) |=> cnt == $past(cnt) + 1'b1);
    // R1
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!clr && !tick) |=> $stable(cnt));
endmodule

// File: rtl/cause_latch.sv
module cause_latch
    import abort_stamp_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             abort_pulse,
    input  logic             dump_hit,
    input  logic             permit_in,
    input  logic             fid_in,
    input  logic             rd_clear,
    input  logic [CNT_W-1:0] cnt,
    output cause_t           flags,
    output logic [CNT_W-1:0] stamp
);
    logic frozen;
    assign frozen = flags.rt_abort && !rd_clear;

    always_ff @(posedge clk) begin
        if (rst) begin
            flags <= '0;
            stamp <= '0;
        end else if (!frozen) begin
            flags.permit_fail <= permit_in;
            flags.fid_fail    <= fid_in;
            flags.dump        <= (flags.dump && !rd_clear) || dump_hit;
            if (abort_pulse) begin
                flags.rt_abort <= 1'b1;
                stamp          <= cnt;
            end else if (rd_clear) begin
                flags.rt_abort <= 1'b0;
            end
        end
    end

    // R3
    capture_chk: assert property (@(posedge clk) disable iff (rst)
        (abort_pulse && !flags.rt_abort) |=> flags.rt_abort && (stamp == $past(cnt)));
    // R4
    freeze_chk: assert property (@(posedge clk) disable iff (rst)
        (flags.rt_abort && !rd_clear) |=> $stable(stamp) && $stable(flags));
    // R7
    release_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_clear && !abort_pulse && !dump_hit) |=> !flags.rt_abort && !flags.dump);
endmodule

// File: rtl/host_regs.sv
module host_regs
    import abort_stamp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CODE_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    input  cause_t            flags,
    input  logic [TS_W-1:0]   stamp,
    output logic [CODE_W-1:0] rd_data,
    output logic [CODE_W-1:0] align_code,
    output logic [CODE_W-1:0] dump_code,
    output logic              rd_clear,
    output logic              irq
);
    logic irq_en;

    assign rd_clear = rd_en && (reg_addr_e'(rd_addr) == A_TS3);
    assign irq      = irq_en && (flags.dump || flags.rt_abort);

    always_ff @(posedge clk) begin
        if (rst) begin
            align_code <= '0;
            dump_code  <= '0;
            irq_en     <= 1'b0;
        end else if (wr_en) begin
            case (reg_addr_e'(wr_addr))
                A_ALIGN:  align_code <= wr_data;
                A_DUMP:   dump_code  <= wr_data;
                A_STATUS: irq_en     <= wr_data[7];
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data <= '0;
        end else if (rd_en) begin
            case (reg_addr_e'(rd_addr))
                A_ALIGN:  rd_data <= align_code;
                A_DUMP:   rd_data <= dump_code;
                A_STATUS: rd_data <= status_byte(flags, irq_en);
                A_TS0:    rd_data <= stamp_byte(stamp, 2'd0);
                A_TS1:    rd_data <= stamp_byte(stamp, 2'd1);
                A_TS2:    rd_data <= stamp_byte(stamp, 2'd2);
                A_TS3:    rd_data <= stamp_byte(stamp, 2'd3);
                default:  rd_data <= '0;
            endcase
        end
    end

    // R10
    wr_code_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && reg_addr_e'(wr_addr) == A_ALIGN) |=> align_code == $past(wr_data));
endmodule

// File: rtl/abort_stamp_unit.sv
module abort_stamp_unit
    import abort_stamp_pkg::*;
#(
    parameter int TICKS_PER_US = 250
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              evt_valid,
    input  logic [7:0]        evt_code,
    input  logic              abort_pulse,
    input  logic              permit_fail_in,
    input  logic              fid_fail_in,
    input  logic              wr_en,
    input  logic [2:0]        wr_addr,
    input  logic [7:0]        wr_data,
    input  logic              rd_en,
    input  logic [2:0]        rd_addr,
    output logic [7:0]        rd_data,
    output logic              irq
);
    logic [CODE_W-1:0] align_code, dump_code;
    logic              align_hit, dump_hit, rd_clear;
    logic [TS_W-1:0]   cnt, stamp;
    cause_t            flags;

    assign align_hit = evt_valid && (evt_code == align_code);
    assign dump_hit  = evt_valid && (evt_code == dump_code);

    us_timebase #(.TICKS_PER_US(TICKS_PER_US), .CNT_W(TS_W)) u_tb (
        .clk(clk), .rst(rst), .clr(align_hit), .cnt(cnt)
    );

    cause_latch #(.CNT_W(TS_W)) u_cause (
        .clk(clk), .rst(rst), .abort_pulse(abort_pulse), .dump_hit(dump_hit),
        .permit_in(permit_fail_in), .fid_in(fid_fail_in), .rd_clear(rd_clear),
        .cnt(cnt), .flags(flags), .stamp(stamp)
    );

    host_regs u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_addr(rd_addr), .flags(flags), .stamp(stamp),
        .rd_data(rd_data), .align_code(align_code), .dump_code(dump_code),
        .rd_clear(rd_clear), .irq(irq)
    );

    // R8
    irq_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_clear && !abort_pulse && !dump_hit) |=> !irq);
    // R5
    dump_ignore_chk: assert property (@(posedge clk) disable iff (rst)
        (flags.rt_abort && !flags.dump && !rd_clear) |=> !flags.dump);
endmodule

// File: tb/sim_abort_stamp_unit.sv
module sim_abort_stamp_unit;
    localparam int TPU = 4;

    logic clk = 1'b0;
    logic rst, evt_valid, abort_pulse, permit_fail_in, fid_fail_in;
    logic wr_en, rd_en, irq;
    logic [7:0] evt_code, wr_data, rd_data;
    logic [2:0] wr_addr, rd_addr;
    int n_cmp = 0, n_bad = 0;
    logic [7:0] b;
    logic [31:0] ts;

    always #2 clk = ~clk;

    abort_stamp_unit #(.TICKS_PER_US(TPU)) u0 (
        .clk(clk), .rst(rst), .evt_valid(evt_valid), .evt_code(evt_code),
        .abort_pulse(abort_pulse), .permit_fail_in(permit_fail_in), .fid_fail_in(fid_fail_in),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk); rd_en = 1'b1; rd_addr = a;
        @(negedge clk); rd_en = 1'b0; d = rd_data;
    endtask

    task automatic evt(input logic [7:0] c);
        @(negedge clk); evt_valid = 1'b1; evt_code = c;
        @(negedge clk); evt_valid = 1'b0;
    endtask

    task automatic abort_now();
        @(negedge clk); abort_pulse = 1'b1;
        @(negedge clk); abort_pulse = 1'b0;
    endtask

    task automatic read_stamp(output logic [31:0] v);
        logic [7:0] x;
        for (int i = 0; i < 4; i++) begin
            rd(3'(3 + i), x);
            v[i*8 +: 8] = x;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        rst = 1'b1; evt_valid = 0; evt_code = 0; abort_pulse = 0;
        permit_fail_in = 0; fid_fail_in = 0; wr_en = 0; rd_en = 0;
        wr_addr = 0; rd_addr = 0; wr_data = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R9 reset state
        for (int a = 0; a < 7; a++) begin
            rd(3'(a), b);
            chk("R9 reset register", {24'd0, b}, 32'd0);
        end
        chk("R9 reset irq", {31'd0, irq}, 32'd0);

        // R10 code registers and status write mask
        wr(3'd0, 8'h5A); wr(3'd1, 8'hC3); wr(3'd2, 8'hFF);
        rd(3'd0, b); chk("R10 align code", {24'd0, b}, 32'h5A);
        rd(3'd1, b); chk("R10 dump code", {24'd0, b}, 32'hC3);
        rd(3'd2, b); chk("R10 status write mask", {24'd0, b}, 32'h80);

        // R1 R2 R3 R7: sweep of gap between alignment and abort
        for (int j = 0; j < 24; j++) begin
            evt(8'h5A);
            repeat (j) @(negedge clk);
            abort_now();
            read_stamp(ts);
            chk($sformatf("R1 R3 stamp gap %0d", j), ts, 32'((j + 1) / TPU));
        end

        // R2 non-matching codes do not clear
        evt(8'h5A);
        repeat (9) @(negedge clk);
        evt(8'h11);
        repeat (9) @(negedge clk);
        abort_now();
        read_stamp(ts);
        chk("R2 other code ignored", ts, 32'((9 + 2 + 9 + 1) / TPU));

        // R4 second abort does not overwrite; R7 partial read does not release
        evt(8'h5A);
        repeat (7) @(negedge clk);
        abort_now();
        repeat (20) @(negedge clk);
        abort_now();
        rd(3'd3, b); rd(3'd4, b); rd(3'd5, b);
        rd(3'd2, b);
        chk("R7 partial read keeps marker", {24'd0, b}, 32'h82);
        chk("R8 irq with marker", {31'd0, irq}, 32'd1);
        read_stamp(ts);
        chk("R4 stamp held", ts, 32'((7 + 1) / TPU));
        chk("R8 irq cleared by final byte", {31'd0, irq}, 32'd0);

        // R5 dump flag and irq
        evt(8'hC3);
        rd(3'd2, b);
        chk("R5 dump flag set", {24'd0, b}, 32'h81);
        chk("R8 irq on dump", {31'd0, irq}, 32'd1);
        read_stamp(ts);
        rd(3'd2, b);
        chk("R7 dump cleared by read", {24'd0, b}, 32'h80);

        // R6 live follow, R4 freeze of permit/fid and dump
        fid_fail_in = 1'b1;
        repeat (2) @(negedge clk);
        rd(3'd2, b);
        chk("R6 fid follows", {24'd0, b}, 32'h88);
        abort_now();
        fid_fail_in = 1'b0; permit_fail_in = 1'b1;
        evt(8'hC3);
        repeat (2) @(negedge clk);
        rd(3'd2, b);
        chk("R4 R5 frozen flags", {24'd0, b}, 32'h8A);
        read_stamp(ts);
        repeat (2) @(negedge clk);
        rd(3'd2, b);
        chk("R6 permit follows after release", {24'd0, b}, 32'h84);
        permit_fail_in = 1'b0;

        // R8 enable off
        wr(3'd2, 8'h00);
        evt(8'hC3);
        chk("R8 irq disabled", {31'd0, irq}, 32'd0);
        rd(3'd2, b);
        chk("R8 flag still set", {24'd0, b}, 32'h01);

        // R9 reset clears registers
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        rd(3'd0, b); chk("R9 align cleared", {24'd0, b}, 32'd0);
        rd(3'd2, b); chk("R9 status cleared", {24'd0, b}, 32'd0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule